// File: doc/BRIEF.md
# Instruction Block Buffer with Midpoint Prefetch

This block sits between the instruction-issue stage of a control unit and a wide array memory. It keeps up to eight blocks of program in local storage. Each block is eight memory words, and each word carries two instructions, so one block holds sixteen instructions. The issue stage presents a program counter counted in instructions. On a hit the buffer returns the instruction in the same cycle. On a miss it raises a stall and asks memory for the whole block.

In straight-line code the buffer looks ahead. When issue reaches the ninth instruction of a block, eight instructions are left in it. At that point the following block is requested, unless it is already resident. Any jumps that may follow are not considered. The memory latency is then hidden behind the eight remaining instructions.

A jump is handled like any other access. If the target block is resident, the jump hits. If not, the jump goes down the same miss path. Blocks arrive word by word and land in slots taken in strict rotation, so the oldest block is always the one overwritten. Only one block fetch may be outstanding at a time.

Top module: `instr_block_buf`

## Requirements
- R1: After reset every slot is empty, so the first instruction requested misses and stalls.
- R2: The block number is pc shifted right by 4, and the word within the block is pc bits 3..1. An even pc selects bits INSTR_W-1..0 of the word, and an odd pc selects the upper half.
- R3: When the block of fetch_pc_i is resident, stall_o stays low and instr_o carries the addressed instruction in the same cycle.
- R4: When the block of fetch_pc_i is neither resident nor being filled, and no fetch is outstanding, stall_o is high and mem_req_o pulses with mem_blk_o equal to that block.
- R5: When an instruction at offset 8 of its block is issued without a stall, no fetch is outstanding, and the next block (block+1) is not resident, mem_req_o pulses with mem_blk_o equal to block+1.
- R6: No request is made for a block that is already resident.
- R7: At most one block fetch is outstanding. mem_req_o never pulses before the eighth word of the previous fetch has arrived. A midpoint prefetch seen while busy is dropped. A miss seen while busy keeps stalling and issues its request once the fetch is complete.
- R8: Returned words are written in order 0..7. A stalled access to the block being filled ends its stall in the cycle after the addressed word has been written.
- R9: Each request claims the next slot in rotation and evicts whatever that slot held. The ninth distinct fetch therefore removes the first block, and a later access to that block misses again.
- R10: With fetch_req_i low, stall_o and mem_req_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req_i | input | 1 | Issue stage wants the instruction at fetch_pc_i |
| fetch_pc_i | input | PC_W | Instruction address, counted in instructions |
| instr_o | output | INSTR_W | Addressed instruction, valid when fetch_req_i and not stall_o |
| stall_o | output | 1 | Requested instruction is not yet available |
| mem_req_o | output | 1 | One-cycle block request to memory |
| mem_blk_o | output | PC_W-4 | Block number requested |
| mem_wvalid_i | input | 1 | A word of the outstanding block is present |
| mem_wdata_i | input | 2*INSTR_W | Returned word, delivered in order 0..7 |

## Verification
A tag or valid bit left wrong has two visible effects. The buffer returns a stale instruction, or it requests a block already held, and either shows on instr_o or mem_req_o in the very cycle the affected block is next addressed. A rotation pointer that skips or stalls goes unnoticed until enough fetches arrive to wrap around. At that point a block that should have been evicted still hits, or a fresh one misses, about eight fetches later. A fill counter that drifts puts words in the wrong place, and this shows as wrong instructions after a jump into the middle of a block that is still arriving.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  localparam int WORDS_PER_BLK = 8;
  localparam int WIDX_W        = 3;
  localparam int OFS_W         = 4;
  localparam logic [OFS_W-1:0] MID_OFS = 4'd8;

  function automatic logic [WIDX_W-1:0] word_of(input logic [OFS_W-1:0] ofs);
    return ofs[OFS_W-1:1];
  endfunction

  function automatic logic is_mid(input logic [OFS_W-1:0] ofs);
    return ofs == MID_OFS;
  endfunction

  function automatic logic last_word(input logic [WIDX_W-1:0] cnt);
    return cnt == WIDX_W'(WORDS_PER_BLK - 1);
  endfunction
endpackage

// File: rtl/ibb_tag_dir.sv
module ibb_tag_dir #(
  parameter int BLK_W  = 12,
  parameter int NBLK   = 8,
  parameter int SLOT_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  look_blk,
  input  logic [BLK_W-1:0]  next_blk,
  input  logic              alloc,
  input  logic [BLK_W-1:0]  alloc_blk,
  input  logic              fill_done,
  output logic [NBLK-1:0]   look_match,
  output logic              look_hit,
  output logic [SLOT_W-1:0] look_slot,
  output logic              next_hit,
  output logic [SLOT_W-1:0] victim,
  output logic [SLOT_W-1:0] fill_slot
);
  logic [BLK_W-1:0] tag_q [NBLK];
  logic [NBLK-1:0]  vld_q;
  logic [NBLK-1:0]  next_match;

  for (genvar i = 0; i < NBLK; i++) begin : g_cmp
    assign look_match[i] = vld_q[i] && (tag_q[i] == look_blk);
    assign next_match[i] = vld_q[i] && (tag_q[i] == next_blk);
  end

  assign look_hit = |look_match;
  assign next_hit = |next_match;

  always_comb begin
    look_slot = '0;
    for (int i = 0; i < NBLK; i++)
      if (look_match[i]) look_slot = SLOT_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      victim    <= '0;
      fill_slot <= '0;
      for (int i = 0; i < NBLK; i++) tag_q[i] <= '0;
    end else if (alloc) begin
      tag_q[victim] <= alloc_blk;
      vld_q[victim] <= 1'b0;
      fill_slot     <= victim;
      victim        <= (victim == SLOT_W'(NBLK - 1)) ? '0 : victim + 1'b1;
    end else if (fill_done) begin
      vld_q[fill_slot] <= 1'b1;
    end
  end
endmodule

// File: rtl/ibb_fetch_ctl.sv
module ibb_fetch_ctl
  import ibb_pkg::*;
#(
  parameter int BLK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want_demand,
  input  logic [BLK_W-1:0]  demand_blk,
  input  logic [WIDX_W-1:0] demand_word,
  input  logic              want_pf,
  input  logic [BLK_W-1:0]  pf_blk,
  input  logic              wvalid,
  output logic              mem_req,
  output logic [BLK_W-1:0]  mem_blk,
  output logic              busy,
  output logic [WIDX_W-1:0] fill_cnt,
  output logic              fill_we,
  output logic              fill_done,
  output logic              demand_partial
);
  logic [BLK_W-1:0] fill_blk;

  assign mem_req   = !busy && (want_demand || want_pf);
  assign mem_blk   = want_demand ? demand_blk : pf_blk;
  assign fill_we   = busy && wvalid;
  assign fill_done = fill_we && last_word(fill_cnt);
  assign demand_partial = busy && (fill_blk == demand_blk) && (demand_word < fill_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fill_blk <= '0;
      fill_cnt <= '0;
    end else if (mem_req) begin
      busy     <= 1'b1;
      fill_blk <= mem_blk;
      fill_cnt <= '0;
    end else if (fill_we) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (last_word(fill_cnt)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ibb_store.sv
module ibb_store
  import ibb_pkg::*;
#(
  parameter int NBLK   = 8,
  parameter int WORD_W = 64,
  parameter int SLOT_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WIDX_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = NBLK * WORDS_PER_BLK;
  localparam int AW    = SLOT_W + WIDX_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wa, ra;

  assign wa      = {wr_slot, wr_word};
  assign ra      = {rd_slot, rd_word};
  assign rd_data = mem_q[ra];

  always_ff @(posedge clk)
    if (we) mem_q[wa] <= wr_data;
endmodule

// File: rtl/instr_block_buf.sv
module instr_block_buf
  import ibb_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int INSTR_W = 32,
  parameter int NBLK    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_req_i,
  input  logic [PC_W-1:0]      fetch_pc_i,
  output logic [INSTR_W-1:0]   instr_o,
  output logic                 stall_o,
  output logic                 mem_req_o,
  output logic [PC_W-5:0]      mem_blk_o,
  input  logic                 mem_wvalid_i,
  input  logic [2*INSTR_W-1:0] mem_wdata_i
);
  localparam int BLK_W  = PC_W - OFS_W;
  localparam int SLOT_W = $clog2(NBLK);
  localparam int WORD_W = 2 * INSTR_W;

  logic [BLK_W-1:0]  cur_blk, nxt_blk;
  logic [OFS_W-1:0]  cur_ofs;
  logic [WIDX_W-1:0] cur_word;
  logic [NBLK-1:0]   look_match;
  logic              resident, next_resident, partial, hit;
  logic [SLOT_W-1:0] look_slot, victim, fill_slot, rd_slot;
  logic              want_demand, want_pf;
  logic              busy, fill_we, fill_done;
  logic [WIDX_W-1:0] fill_cnt;
  logic [WORD_W-1:0] rd_data;

  assign cur_blk  = fetch_pc_i[PC_W-1:OFS_W];
  assign cur_ofs  = fetch_pc_i[OFS_W-1:0];
  assign cur_word = word_of(cur_ofs);
  assign nxt_blk  = cur_blk + 1'b1;

  assign hit         = resident || partial;
  assign want_demand = fetch_req_i && !resident && !partial &&
                       !(busy && 1'b1);
  assign want_pf     = fetch_req_i && hit && is_mid(cur_ofs) && !next_resident;
  assign stall_o     = fetch_req_i && !hit;
  assign rd_slot     = resident ? look_slot : fill_slot;
  assign instr_o     = fetch_pc_i[0] ? rd_data[WORD_W-1:INSTR_W] : rd_data[INSTR_W-1:0];

  ibb_tag_dir #(.BLK_W(BLK_W), .NBLK(NBLK), .SLOT_W(SLOT_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_blk   (cur_blk),
    .next_blk   (nxt_blk),
    .alloc      (mem_req_o),
    .alloc_blk  (mem_blk_o),
    .fill_done  (fill_done),
    .look_match (look_match),
    .look_hit   (resident),
    .look_slot  (look_slot),
    .next_hit   (next_resident),
    .victim     (victim),
    .fill_slot  (fill_slot)
  );

  ibb_fetch_ctl #(.BLK_W(BLK_W)) u_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .want_demand    (want_demand),
    .demand_blk     (cur_blk),
    .demand_word    (cur_word),
    .want_pf        (want_pf),
    .pf_blk         (nxt_blk),
    .wvalid         (mem_wvalid_i),
    .mem_req        (mem_req_o),
    .mem_blk        (mem_blk_o),
    .busy           (busy),
    .fill_cnt       (fill_cnt),
    .fill_we        (fill_we),
    .fill_done      (fill_done),
    .demand_partial (partial)
  );

  ibb_store #(.NBLK(NBLK), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_store (
    .clk     (clk),
    .we      (fill_we),
    .wr_slot (fill_slot),
    .wr_word (fill_cnt),
    .wr_data (mem_wdata_i),
    .rd_slot (rd_slot),
    .rd_word (cur_word),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ibb_checker.sv
module ibb_checker #(
  parameter int NBLK   = 8,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              stall,
  input logic              mem_req,
  input logic              busy,
  input logic              wvalid,
  input logic [2:0]        fill_cnt,
  input logic [3:0]        pc_ofs,
  input logic [NBLK-1:0]   match,
  input logic [SLOT_W-1:0] victim
);
  AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !busy); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wvalid) |=> busy); // R7
  AST_FILL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wvalid && fill_cnt == 3'd7) |=> !busy); // R8
  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> fetch_req); // R10
  AST_QUIET_NO_MEMREQ: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> !mem_req); // R10
  AST_PF_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !stall) |-> (pc_ofs == 4'd8)); // R5
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R6
  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> victim == (($past(victim) == SLOT_W'(NBLK - 1)) ? '0 : $past(victim) + 1'b1)); // R9
endmodule

bind instr_block_buf ibb_checker #(.NBLK(NBLK), .SLOT_W(SLOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_req (fetch_req_i),
  .stall     (stall_o),
  .mem_req   (mem_req_o),
  .busy      (busy),
  .wvalid    (mem_wvalid_i),
  .fill_cnt  (fill_cnt),
  .pc_ofs    (cur_ofs),
  .match     (look_match),
  .victim    (victim)
);

// File: tb/instr_block_buf_test.sv
module instr_block_buf_test;
  localparam int PC_W = 16, INSTR_W = 32, NBLK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_req_i = 1'b0;
  logic [PC_W-1:0] fetch_pc_i = '0;
  logic [INSTR_W-1:0] instr_o;
  logic stall_o, mem_req_o;
  logic [PC_W-5:0] mem_blk_o;
  logic mem_wvalid_i = 1'b0;
  logic [2*INSTR_W-1:0] mem_wdata_i = '0;

  instr_block_buf #(.PC_W(PC_W), .INSTR_W(INSTR_W), .NBLK(NBLK)) uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int prog[$];
  int m_tag[NBLK];
  bit m_vld[NBLK];
  int m_ptr = 0, m_fblk = 0, m_fslot = 0, m_fcnt = 0;
  bit m_busy = 0;
  int r_blk = 0, r_wait = 0, r_cnt = 0;
  bit r_act = 0;
  bit first_req = 1;
  int cycles = 0;
  bit timed_out = 0;

  function automatic logic [INSTR_W-1:0] ins_at(int pc);
    int b = pc >> 4, w = (pc >> 1) & 7, h = pc & 1;
    return INSTR_W'(b * 2654435 + w * 40503 + h * 977) ^ 32'h5A3C0000;
  endfunction

  function automatic logic [2*INSTR_W-1:0] mword(int b, int w);
    return {ins_at(b * 16 + w * 2 + 1), ins_at(b * 16 + w * 2)};
  endfunction

  function automatic bit resident(int b);
    for (int i = 0; i < NBLK; i++) if (m_vld[i] && m_tag[i] == b) return 1;
    return 0;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (pc %0h, t=%0t)", req, act, exp, fetch_pc_i, $time);
    end
  endtask

  task automatic push_run(int start, int n);
    for (int i = 0; i < n; i++) prog.push_back(start + i);
  endtask

  task automatic push_idle(int n);
    for (int i = 0; i < n; i++) prog.push_back(-1);
  endtask

  initial begin
    for (int i = 0; i < NBLK; i++) begin m_tag[i] = 0; m_vld[i] = 0; end
    push_idle(3);
    push_run(0, 80);          // straight line, midpoint prefetches
    push_run(16'h400, 10);    // jump miss, then prefetch at offset 8
    push_run(16, 20);         // jump back into resident blocks
    push_idle(2);
    push_run(16'h808 - 8, 9); // reach midpoint of block 0x80
    push_run(16'h900, 4);     // jump miss while prefetch outstanding
    push_run(0, 4);           // block 0 was evicted
    push_run(16'h1008, 12);   // enter a block at its midpoint
    push_run(16'h1003, 3);    // back into a block just filled
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    check("R1 reset stall", stall_o, 0);
    check("R1 reset memreq", mem_req_o, 0);
    while (prog.size() > 0 && !timed_out) begin
      int pc, b, wd, nb;
      bit req, res, part, hit, wantd, wantp, e_stall, e_mreq, a_stall, a_mreq, wv;
      int e_mblk, a_mblk;
      @(negedge clk);
      pc  = prog[0];
      req = (pc >= 0);
      fetch_req_i = req;
      fetch_pc_i  = req ? PC_W'(pc) : '0;
      wv = r_act && (r_wait == 0);
      mem_wvalid_i = wv;
      mem_wdata_i  = wv ? mword(r_blk, r_cnt) : '0;
      #2;
      b  = req ? pc >> 4 : 0;
      wd = req ? (pc >> 1) & 7 : 0;
      nb = (b + 1) & 12'hFFF;
      res   = req && resident(b);
      part  = req && m_busy && m_fblk == b && wd < m_fcnt;
      hit   = res || part;
      e_stall = req && !hit;
      wantd = req && !hit;
      wantp = req && hit && ((pc & 15) == 8) && !resident(nb);
      e_mreq = !m_busy && (wantd || wantp);
      e_mblk = wantd ? b : nb;
      a_stall = stall_o; a_mreq = mem_req_o; a_mblk = int'(mem_blk_o);
      if (!req) begin
        check("R10 stall", a_stall, 0);
        check("R10 memreq", a_mreq, 0);
      end else begin
        if (first_req) begin
          check("R1 first access stall", a_stall, 1);
          first_req = 0;
        end
        if (e_stall) check(m_busy ? "R7 miss waits/R8 fill stall" : "R4 miss stall", a_stall, 1);
        else check(part ? "R8 partial hit" : "R3 hit", a_stall, 0);
        if (wantp) check(m_busy ? "R7 prefetch dropped" : "R5 prefetch", a_mreq, e_mreq);
        else if (wantd) check(m_busy ? "R7 one outstanding" : "R4 / R9 miss request", a_mreq, e_mreq);
        else check("R6 no request", a_mreq, 0);
        if (e_mreq) check(wantp ? "R5 block" : "R4 block", a_mblk, e_mblk);
        if (!e_stall && !a_stall) check("R2 instr", instr_o, ins_at(pc));
      end
      // reference model update for this edge
      if (e_mreq) begin
        m_tag[m_ptr] = e_mblk; m_vld[m_ptr] = 0; m_fslot = m_ptr;
        m_ptr = (m_ptr + 1) % NBLK; m_busy = 1; m_fblk = e_mblk; m_fcnt = 0;
      end else if (m_busy && wv) begin
        m_fcnt++;
        if (m_fcnt == 8) begin m_vld[m_fslot] = 1; m_busy = 0; end
      end
      // memory responder: 3-cycle latency, one gap after word 4
      if (wv) begin
        r_cnt++;
        if (r_cnt == 8) r_act = 0;
        else if (r_cnt == 4) r_wait = 1;
      end else if (r_act && r_wait > 0) r_wait--;
      if (a_mreq) begin r_act = 1; r_blk = a_mblk; r_wait = 3; r_cnt = 0; end
      if (!req || !a_stall) void'(prog.pop_front());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !timed_out) begin
      timed_out = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
    end
  end
endmodule